// File: doc/BRIEF.md
# System Control Register and Bus Decoder

This block sits on the bus of an 8-bit CPU with separate memory and I/O request strobes. It holds a single control byte. It turns each bus cycle into the chip selects that the memories and peripherals need. The same byte gates the write enable of main RAM, picks the CPU clock enable, and tells the read-data multiplexer which source drives the CPU data input.

The control byte changes the machine in three ways:
- Bit 0 hides a boot ROM that otherwise covers the bottom quarter of memory.
- Bit 1 forces the CPU to run on every clock instead of on a slow tick.
- Bit 2 write-protects the upper half of RAM.

The memory map and the I/O map are fixed, partially decoded windows. Every select, the write enable, the clock enable and the source code are combinational in the current bus signals and the stored byte. The control byte itself is loaded at a clock edge.

Top module: `sysbus_ctrl`

## Requirements
- R1: A clock edge with `rst_n` low clears the control byte `ctrl_q` to 0x00. After reset the boot ROM is visible, turbo is off and write protection is off.
- R2: `ctrl_q` loads `wdata` at a clock edge only when all of the following hold at that edge:
  - `iorq_n` is low and `m1_n` is high;
  - `addr[7:0]` equals 0x02 (`addr[15:8]` is ignored);
  - `wr_n` is low.
  At every other edge it holds its value.
- R3: `boot_sel_n` is low exactly when `mreq_n` is low, `addr[15:14]` is 00 and `ctrl_q[0]` is 0.
- R4: `cpu_ce` is high when `ctrl_q[1]` is 1. Otherwise it follows `slow_tick`.
- R5: `ram_we` is high exactly when `mreq_n` and `wr_n` are both low and the write is not blocked. A write is blocked when `ctrl_q[2]` is 1 and `addr[15]` is 1. Addresses below 0x8000 stay writable.
- R6: `color_sel_n` is low for memory cycles with `addr[15:10]` = 111010 (0xE800–0xEBFF). `char_sel_n` is low for memory cycles with `addr[15:10]` = 111011 (0xEC00–0xEFFF). Both stay high when `mreq_n` is high.
- R7: During an I/O cycle (`iorq_n` low, `m1_n` high), decoding uses `addr[7:0]` only:
  - serial 0x00–0x01;
  - SPI 0x04–0x07;
  - timer 0x80–0x87;
  - parallel A 0x88–0x8F;
  - parallel B 0x90–0x97;
  - control 0x02.
  At most one I/O select is low.
- R8: `ram_sel_n` equals `mreq_n`. RAM writes under the boot overlay and inside the video windows still raise `ram_we`.
- R9: `rd_src` gives the first matching source in this order, with these codes:
  - 0: timer
  - 1: parallel A
  - 2: parallel B
  - 3: serial
  - 4: SPI
  - 5: boot ROM
  - 6: control byte
  - 7: color RAM
  - 8: character RAM
  - 9: main RAM (when nothing else matches)
- R10: `ack_timer`, `ack_pio_a` and `ack_pio_b` each force their source (code 0, 1 and 2) onto `rd_src` by the same priority, even when the matching I/O select is inactive.
- R11: All I/O selects stay high during an interrupt-acknowledge cycle (`m1_n` and `iorq_n` both low) and whenever `iorq_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 16 | CPU address |
| wdata | input | 8 | CPU data out |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| m1_n | input | 1 | Opcode fetch / acknowledge cycle, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ack_timer | input | 1 | Timer interrupt acknowledge in progress |
| ack_pio_a | input | 1 | Parallel port A acknowledge in progress |
| ack_pio_b | input | 1 | Parallel port B acknowledge in progress |
| slow_tick | input | 1 | Slow system clock-enable pulse |
| boot_sel_n | output | 1 | Boot ROM select |
| ram_sel_n | output | 1 | Main RAM select |
| color_sel_n | output | 1 | Color RAM select |
| char_sel_n | output | 1 | Character RAM select |
| serial_sel_n | output | 1 | Serial port select |
| spi_sel_n | output | 1 | SPI port select |
| timer_sel_n | output | 1 | Counter/timer select |
| pio_a_sel_n | output | 1 | Parallel port A select |
| pio_b_sel_n | output | 1 | Parallel port B select |
| ctrl_sel_n | output | 1 | Control byte select |
| ram_we | output | 1 | Gated main RAM write enable |
| cpu_ce | output | 1 | CPU clock enable |
| rd_src | output | 4 | Read-data multiplexer source code |
| ctrl_q | output | 8 | Control byte |

## Verification
Results fall into two timing classes:
- **Same cycle.** Every select, `ram_we`, `cpu_ce` and `rd_src` is combinational. The bench drives each bus cycle on the falling clock edge and compares these outputs 2 ns later, before the next rising edge.
- **One edge later.** `ctrl_q` only changes on a rising edge. The bench updates its own copy of the byte at that edge and compares `ctrl_q` 1 ns after it.

Effects of a control write on the decoding are therefore first checked in the bus cycle that follows the write.

// File: rtl/sysbus_pkg.sv
// Shared constants and types for the system control / bus decoder.
// Assumes an 8-bit data bus and a 16-bit address bus with an 8-bit I/O space.
package sysbus_pkg;

    // I/O port indices into the select vector
    localparam int IO_N      = 6;
    localparam int IO_SERIAL = 0;
    localparam int IO_SPI    = 1;
    localparam int IO_TIMER  = 2;
    localparam int IO_PIOA   = 3;
    localparam int IO_PIOB   = 4;
    localparam int IO_CTRL   = 5;

    // Base of each I/O window and the number of low address bits it ignores
    localparam logic [7:0] IO_BASE [IO_N] = '{8'h00, 8'h04, 8'h80, 8'h88, 8'h90, 8'h02};
    localparam int         IO_SPAN [IO_N] = '{1, 2, 3, 3, 3, 0};

    // Control byte bit positions
    localparam int CB_BOOT_HIDE = 0;
    localparam int CB_TURBO     = 1;
    localparam int CB_WPROT     = 2;

    // Read-data source codes, listed in priority order
    typedef enum logic [3:0] {
        SRC_TIMER = 4'd0,
        SRC_PIOA  = 4'd1,
        SRC_PIOB  = 4'd2,
        SRC_SER   = 4'd3,
        SRC_SPI   = 4'd4,
        SRC_BOOT  = 4'd5,
        SRC_CTRL  = 4'd6,
        SRC_COLOR = 4'd7,
        SRC_CHAR  = 4'd8,
        SRC_RAM   = 4'd9
    } src_e;

endpackage

// File: rtl/sysctl_reg.sv
// Control byte register.
// Loads the write data on a clock edge where its select and the write strobe
// are both low. Assumes a synchronous active-low reset that clears the byte.
module sysctl_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q
);

    logic load;
    assign load = !sel_n && !wr_n;

    // Hold or update the control byte
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (load)
            ctrl_q <= wdata;
    end

    // R2
    ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !wr_n) |=> (ctrl_q == $past(wdata)));

    // R2
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sel_n && !wr_n) |=> $stable(ctrl_q));

endmodule

// File: rtl/mem_decode.sv
// Memory-side decoder.
// Produces the boot ROM, main RAM and video window selects, plus the gated
// main RAM write enable. Assumes only the address bits above the window
// size are presented.
module mem_decode #(
    parameter int         HI_W       = 6,
    parameter int         BOOT_W     = 2,
    parameter logic [5:0] COLOR_TAG  = 6'b111010,
    parameter logic [5:0] CHAR_TAG   = 6'b111011
) (
    input  logic [HI_W-1:0] hi_addr,
    input  logic            mreq_n,
    input  logic            wr_n,
    input  logic            boot_hide,
    input  logic            wprot,
    output logic            boot_sel_n,
    output logic            ram_sel_n,
    output logic            color_sel_n,
    output logic            char_sel_n,
    output logic            ram_we
);

    localparam int TOP = HI_W - 1;

    logic mem_cyc;
    logic upper;
    assign mem_cyc = !mreq_n;
    assign upper   = hi_addr[TOP];

    // Window selects
    always_comb begin
        boot_sel_n  = !(mem_cyc && !boot_hide && (hi_addr[TOP -: BOOT_W] == '0));
        color_sel_n = !(mem_cyc && (hi_addr == COLOR_TAG));
        char_sel_n  = !(mem_cyc && (hi_addr == CHAR_TAG));
        ram_sel_n   = mreq_n;
    end

    // RAM write gating with upper-half protection
    always_comb begin
        ram_we = mem_cyc && !wr_n && !(wprot && upper);
    end

endmodule

// File: rtl/io_decode.sv
// I/O-side decoder.
// Compares the low address byte against each fixed port window during a
// plain I/O cycle (request low, fetch/acknowledge high).
module io_decode
    import sysbus_pkg::*;
(
    input  logic [7:0]      io_addr,
    input  logic            iorq_n,
    input  logic            m1_n,
    output logic [IO_N-1:0] io_sel_n
);

    logic io_cyc;
    assign io_cyc = !iorq_n && m1_n;

    // One comparator per window, masking the ignored low bits
    for (genvar g = 0; g < IO_N; g++) begin : g_port
        assign io_sel_n[g] = !(io_cyc && ((io_addr >> IO_SPAN[g]) == (IO_BASE[g] >> IO_SPAN[g])));
    end

endmodule

// File: rtl/rd_src_sel.sv
// Read-data source priority encoder.
// Interrupt acknowledge flags of the first three peripherals count as selects.
module rd_src_sel
    import sysbus_pkg::*;
(
    input  logic [IO_N-1:0] io_sel_n,
    input  logic            ack_timer,
    input  logic            ack_pio_a,
    input  logic            ack_pio_b,
    input  logic            boot_sel_n,
    input  logic            color_sel_n,
    input  logic            char_sel_n,
    output src_e            src
);

    // Fixed-priority choice of the source driving the CPU data input
    always_comb begin
        if (!io_sel_n[IO_TIMER] || ack_timer)      src = SRC_TIMER;
        else if (!io_sel_n[IO_PIOA] || ack_pio_a)  src = SRC_PIOA;
        else if (!io_sel_n[IO_PIOB] || ack_pio_b)  src = SRC_PIOB;
        else if (!io_sel_n[IO_SERIAL])             src = SRC_SER;
        else if (!io_sel_n[IO_SPI])                src = SRC_SPI;
        else if (!boot_sel_n)                      src = SRC_BOOT;
        else if (!io_sel_n[IO_CTRL])               src = SRC_CTRL;
        else if (!color_sel_n)                     src = SRC_COLOR;
        else if (!char_sel_n)                      src = SRC_CHAR;
        else                                       src = SRC_RAM;
    end

endmodule

// File: rtl/sysbus_ctrl.sv
// System control and bus decoder top.
// Connects the control byte, the memory and I/O decoders and the read-source
// encoder. Every output except the control byte is combinational in the bus.
module sysbus_ctrl
    import sysbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              mreq_n,
    input  logic              iorq_n,
    input  logic              m1_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              ack_timer,
    input  logic              ack_pio_a,
    input  logic              ack_pio_b,
    input  logic              slow_tick,
    output logic              boot_sel_n,
    output logic              ram_sel_n,
    output logic              color_sel_n,
    output logic              char_sel_n,
    output logic              serial_sel_n,
    output logic              spi_sel_n,
    output logic              timer_sel_n,
    output logic              pio_a_sel_n,
    output logic              pio_b_sel_n,
    output logic              ctrl_sel_n,
    output logic              ram_we,
    output logic              cpu_ce,
    output logic [3:0]        rd_src,
    output logic [DATA_W-1:0] ctrl_q
);

    localparam int HI_W = 6;
    localparam int IO_W = 8;

    logic [IO_N-1:0] io_sel_n;
    src_e            src;
    logic            unused_bits;

    assign unused_bits = ^{addr[ADDR_W-HI_W-1:IO_W], rd_n};

    sysctl_reg #(.DATA_W(DATA_W)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_n  (io_sel_n[IO_CTRL]),
        .wr_n   (wr_n),
        .wdata  (wdata),
        .ctrl_q (ctrl_q)
    );

    mem_decode #(.HI_W(HI_W)) u_mem (
        .hi_addr     (addr[ADDR_W-1 -: HI_W]),
        .mreq_n      (mreq_n),
        .wr_n        (wr_n),
        .boot_hide   (ctrl_q[CB_BOOT_HIDE]),
        .wprot       (ctrl_q[CB_WPROT]),
        .boot_sel_n  (boot_sel_n),
        .ram_sel_n   (ram_sel_n),
        .color_sel_n (color_sel_n),
        .char_sel_n  (char_sel_n),
        .ram_we      (ram_we)
    );

    io_decode u_io (
        .io_addr  (addr[IO_W-1:0]),
        .iorq_n   (iorq_n),
        .m1_n     (m1_n),
        .io_sel_n (io_sel_n)
    );

    rd_src_sel u_src (
        .io_sel_n    (io_sel_n),
        .ack_timer   (ack_timer),
        .ack_pio_a   (ack_pio_a),
        .ack_pio_b   (ack_pio_b),
        .boot_sel_n  (boot_sel_n),
        .color_sel_n (color_sel_n),
        .char_sel_n  (char_sel_n),
        .src         (src)
    );

    // Fan the I/O select vector out to named ports
    always_comb begin
        serial_sel_n = io_sel_n[IO_SERIAL];
        spi_sel_n    = io_sel_n[IO_SPI];
        timer_sel_n  = io_sel_n[IO_TIMER];
        pio_a_sel_n  = io_sel_n[IO_PIOA];
        pio_b_sel_n  = io_sel_n[IO_PIOB];
        ctrl_sel_n   = io_sel_n[IO_CTRL];
    end

    // CPU clock enable: turbo override or slow tick
    assign cpu_ce = ctrl_q[CB_TURBO] || slow_tick;
    assign rd_src = src;

    // R5
    wprot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && addr[ADDR_W-1]) |-> !ctrl_q[CB_WPROT]);

    // R3
    boot_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_sel_n |-> (!ctrl_q[CB_BOOT_HIDE] && !mreq_n));

    // R4
    turbo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[CB_TURBO] |-> cpu_ce);

    // R7
    io_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~io_sel_n));

    // R11
    io_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!m1_n || iorq_n) |-> (&io_sel_n));

    // R10
    ack_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_timer |-> (src == SRC_TIMER));

    // R9
    boot_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_BOOT) |-> !boot_sel_n);

endmodule

// File: tb/sysbus_ctrl_test.sv
// Self-checking bench: random bus cycles with directed boundary addresses,
// compared against a model of the control byte and the decode rules.
module sysbus_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic        mreq_n, iorq_n, m1_n, rd_n, wr_n;
    logic        ack_timer, ack_pio_a, ack_pio_b, slow_tick;
    logic        boot_sel_n, ram_sel_n, color_sel_n, char_sel_n;
    logic        serial_sel_n, spi_sel_n, timer_sel_n, pio_a_sel_n, pio_b_sel_n, ctrl_sel_n;
    logic        ram_we, cpu_ce;
    logic [3:0]  rd_src;
    logic [7:0]  ctrl_q;

    int   n_chk  = 0;
    int   n_fail = 0;
    logic [7:0] m_ctrl;

    always #10 clk = ~clk;

    sysbus_ctrl uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .mreq_n(mreq_n), .iorq_n(iorq_n), .m1_n(m1_n), .rd_n(rd_n), .wr_n(wr_n),
        .ack_timer(ack_timer), .ack_pio_a(ack_pio_a), .ack_pio_b(ack_pio_b),
        .slow_tick(slow_tick),
        .boot_sel_n(boot_sel_n), .ram_sel_n(ram_sel_n), .color_sel_n(color_sel_n),
        .char_sel_n(char_sel_n), .serial_sel_n(serial_sel_n), .spi_sel_n(spi_sel_n),
        .timer_sel_n(timer_sel_n), .pio_a_sel_n(pio_a_sel_n), .pio_b_sel_n(pio_b_sel_n),
        .ctrl_sel_n(ctrl_sel_n), .ram_we(ram_we), .cpu_ce(cpu_ce),
        .rd_src(rd_src), .ctrl_q(ctrl_q)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected I/O selects, active low: {ctrl, pioB, pioA, timer, spi, serial}
    function automatic logic [5:0] f_io(input logic [15:0] a, input logic iq, input logic m1);
        logic [5:0] s;
        logic [7:0] lo;
        lo = a[7:0];
        s  = 6'h3F;
        if (!iq && m1) begin
            s[0] = !(lo <= 8'h01);
            s[1] = !(lo >= 8'h04 && lo <= 8'h07);
            s[2] = !(lo >= 8'h80 && lo <= 8'h87);
            s[3] = !(lo >= 8'h88 && lo <= 8'h8F);
            s[4] = !(lo >= 8'h90 && lo <= 8'h97);
            s[5] = !(lo == 8'h02);
        end
        return s;
    endfunction

    function automatic logic f_boot(input logic [15:0] a, input logic mq, input logic [7:0] c);
        return !(!mq && !c[0] && a < 16'h4000);
    endfunction

    function automatic logic [1:0] f_vid(input logic [15:0] a, input logic mq);
        return {!(!mq && a >= 16'hE800 && a <= 16'hEBFF), !(!mq && a >= 16'hEC00 && a <= 16'hEFFF)};
    endfunction

    function automatic int f_src(input logic [5:0] io, input logic bt, input logic [1:0] vid,
                                 input logic at, input logic aa, input logic ab);
        if (!io[2] || at) return 0;
        if (!io[3] || aa) return 1;
        if (!io[4] || ab) return 2;
        if (!io[0])       return 3;
        if (!io[1])       return 4;
        if (!bt)          return 5;
        if (!io[5])       return 6;
        if (!vid[1])      return 7;
        if (!vid[0])      return 8;
        return 9;
    endfunction

    // One bus cycle: drive at falling edge, check combinational outputs, then the edge
    task automatic step(input logic [15:0] a, input int kind, input logic [7:0] d,
                        input logic at, input logic aa, input logic ab, input logic tk);
        logic [5:0] e_io;
        logic       e_bt;
        logic [1:0] e_vid;
        logic       is_wr;
        @(negedge clk);
        addr = a; wdata = d; ack_timer = at; ack_pio_a = aa; ack_pio_b = ab; slow_tick = tk;
        // kinds: 0 mem rd, 1 mem wr, 2 fetch, 3 io rd, 4 io wr, 5 int ack, 6 idle
        mreq_n = !(kind <= 2);
        iorq_n = !(kind == 3 || kind == 4 || kind == 5);
        m1_n   = !(kind == 2 || kind == 5);
        rd_n   = !(kind == 0 || kind == 2 || kind == 3);
        wr_n   = !(kind == 1 || kind == 4);
        #2;
        e_io  = f_io(a, iorq_n, m1_n);
        e_bt  = f_boot(a, mreq_n, m_ctrl);
        e_vid = f_vid(a, mreq_n);
        chk("R3 boot select", boot_sel_n, e_bt);
        chk("R8 ram select", ram_sel_n, mreq_n);
        chk("R6 video selects", {color_sel_n, char_sel_n}, e_vid);
        if (kind == 5 || iorq_n)
            chk("R11 io selects muted", {ctrl_sel_n, pio_b_sel_n, pio_a_sel_n, timer_sel_n, spi_sel_n, serial_sel_n}, 6'h3F);
        else
            chk("R7 io selects", {ctrl_sel_n, pio_b_sel_n, pio_a_sel_n, timer_sel_n, spi_sel_n, serial_sel_n}, e_io);
        chk("R5 ram write enable", ram_we, !mreq_n && !wr_n && !(m_ctrl[2] && a[15]));
        chk("R4 cpu clock enable", cpu_ce, tk || m_ctrl[1]);
        if (at || aa || ab)
            chk("R10 ack source", rd_src, f_src(e_io, e_bt, e_vid, at, aa, ab));
        else
            chk("R9 read source", rd_src, f_src(e_io, e_bt, e_vid, at, aa, ab));
        is_wr = !iorq_n && m1_n && !wr_n && a[7:0] == 8'h02;
        @(posedge clk);
        #1;
        if (!rst_n)     m_ctrl = 8'h00;
        else if (is_wr) m_ctrl = d;
        chk(rst_n ? "R2 control byte" : "R1 reset value", ctrl_q, m_ctrl);
    endtask

    function automatic logic [15:0] pick_mem();
        case ($urandom_range(0, 11))
            0: return 16'h0000; 1: return 16'h3FFF; 2: return 16'h4000; 3: return 16'h7FFF;
            4: return 16'h8000; 5: return 16'hE7FF; 6: return 16'hE800; 7: return 16'hEBFF;
            8: return 16'hEC00; 9: return 16'hEFFF; 10: return 16'hF000; default: return 16'hFFFF;
        endcase
    endfunction

    function automatic logic [7:0] pick_io();
        case ($urandom_range(0, 14))
            0: return 8'h00; 1: return 8'h01; 2: return 8'h02; 3: return 8'h03; 4: return 8'h04;
            5: return 8'h07; 6: return 8'h08; 7: return 8'h7F; 8: return 8'h80; 9: return 8'h87;
            10: return 8'h88; 11: return 8'h8F; 12: return 8'h90; 13: return 8'h97; default: return 8'h98;
        endcase
    endfunction

    // Watchdog: a hung run counts as one failure and still prints the summary
    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] a;
        int          k;
        void'($urandom(32'd20240611));
        m_ctrl = 8'h00;
        rst_n = 1'b0; addr = '0; wdata = '0; mreq_n = 1; iorq_n = 1; m1_n = 1; rd_n = 1; wr_n = 1;
        ack_timer = 0; ack_pio_a = 0; ack_pio_b = 0; slow_tick = 0;
        @(posedge clk); @(posedge clk);
        step(16'h0000, 6, 8'h00, 0, 0, 0, 0);              // R1 reset state
        rst_n = 1'b1;
        step(16'h0000, 0, 8'h00, 0, 0, 0, 0);              // R3 boot visible after reset
        step(16'hAB02, 4, 8'h06, 0, 0, 0, 0);              // R2 write with upper byte ignored
        step(16'h8000, 1, 8'h00, 0, 0, 0, 0);              // R5 upper write blocked
        step(16'h7FFF, 1, 8'h00, 0, 0, 0, 0);              // R5 lower write allowed
        step(16'h0002, 5, 8'hFF, 1, 0, 0, 0);              // R11 ack cycle does not write
        step(16'h0002, 4, 8'h01, 0, 0, 0, 0);              // R2 hide boot ROM
        step(16'h1000, 1, 8'h00, 0, 0, 0, 1);              // R3/R8 RAM under overlay
        step(16'h0090, 3, 8'h00, 0, 1, 0, 0);              // R10 ack beats pio B select
        for (int i = 0; i < 4000; i++) begin
            k = $urandom_range(0, 3);
            case (k)
                0: a = 16'($urandom);
                1: a = pick_mem();
                2: a = {8'($urandom), pick_io()};
                default: a = {8'($urandom), 8'h02};
            endcase
            step(a, int'($urandom_range(0, 6)), 8'($urandom),
                 $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0,
                 $urandom_range(0, 9) == 0, $urandom_range(0, 3) == 0);
        end
        step(16'h0002, 4, 8'hFF, 0, 0, 0, 0);
        rst_n = 1'b0;
        step(16'h0000, 6, 8'h00, 0, 0, 0, 0);              // R1 reset clears a set byte
        rst_n = 1'b1;
        step(16'h0000, 0, 8'h00, 0, 0, 0, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule